// File: doc/BRIEF.md
# Duty-Cycle Calibration Search Sequencer

This block calibrates the duty-cycle correction code of a chain of clock-path units, one unit after another. For each unit it presents a 7-bit adjust code to an external duty-cycle detector, waits a fixed settle interval, and reads the detector's one-bit compare answer. It moves the code one step at a time until that answer flips. The first answer after the seed is applied sets the direction of the walk. A walk that runs into the top or bottom code fails.

Every unit is measured twice. The first pass uses side A and starts from the current seed. The second pass uses side B and starts one code below side A's final code, clamped at zero. The two codes are merged into the unit's final code. When both sides pass, the merged code is their average rounded down. When only one side passes, its code is used. When both fail, the sequence stops and reports the unit. The merged code is written out with a one-cycle strobe and becomes the seed of the next unit. The first unit starts at mid-scale.

Around the searches, the block first sends every unit a configuration strobe that turns off the unit's calibration-update enable and its calibration-good flag. After the last unit has been written, it sends a second round of strobes that turns the update enable back on. A one-cycle done pulse then ends the run.

Top module: `dcc_cal_seq`

## Requirements
- R1: While synchronous active-high reset is asserted and in the cycle after it is released, every output is 0. This includes busy, done, fail, det_code, det_corr_en, det_side_a, dll_wr, wr_en and unit_addr.
- R2: The first unit is searched from code 64. The first compare sample taken after a seed is applied sets the direction of the search. If it is 0, the code rises by 1 per sample until compare reads 1. If it is 1, the code falls by 1 per sample until compare reads 0. That side's result is the code at which the sample flipped.
- R3: A side fails if its code reaches 127 while rising or 0 while falling. This holds even if compare flips at that code. A side whose seed already sits at the limit in the chosen direction fails on its first sample, without stepping.
- R4: Every new code stays on det_code for SETTLE (128) clock cycles before the compare sample that belongs to it is taken. A detector that answers wrongly until its input has been stable for that long must not change any result.
- R5: Side A is searched with det_side_a=1 and is seeded with the current seed. Side B is searched next with det_side_a=0 and is seeded with side A's final code minus 1. When side A's final code is 0, side B's seed stays at 0. det_corr_en is 1 while the block waits for a compare sample.
- R6: If both sides pass, the unit's code is floor((A+B)/2). If only one side passes, that side's code is used.
- R7: Each calibrated unit produces exactly one wr_en pulse, with unit_addr set to the unit index and wr_code set to the merged code. wr_cmp is 0 on every write. Units are written in the order 0 to NUM_UNITS-1, and each merged code seeds the next unit.
- R8: Before the first search, dll_wr pulses once per unit, in index order on unit_addr, with dll_update_en=0. After the last unit is written, dll_wr pulses once more per unit, in index order, with dll_update_en=1. dll_good is 0 on every dll_wr.
- R9: On a successful run, done is high for exactly one cycle, after the final restore strobe. busy is low in that cycle.
- R10: If both sides of a unit fail, the run stops at once. fail goes high and holds, fail_unit gives that unit's index, no further wr_en or dll_wr occurs, and done does not pulse. The next start clears fail.
- R11: A start that arrives while busy is high has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a calibration run when the block is idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when a run completes successfully |
| fail | output | 1 | Set when both sides of a unit fail; held until the next start |
| fail_unit | output | IDX_W | Index of the unit that failed |
| unit_addr | output | IDX_W | Unit currently addressed by a search or a strobe |
| det_code | output | CODE_W | Adjust code presented to the detector |
| det_corr_en | output | 1 | Correction enable to the detector, high while awaiting a sample |
| det_side_a | output | 1 | Side select: 1 for side A, 0 for side B |
| det_compare | input | 1 | Detector compare answer |
| dll_wr | output | 1 | Configuration strobe for the addressed unit |
| dll_update_en | output | 1 | Update-enable value carried with dll_wr |
| dll_good | output | 1 | Calibration-good value carried with dll_wr (always 0) |
| wr_en | output | 1 | Final-code write strobe for the addressed unit |
| wr_code | output | CODE_W | Final code carried with wr_en |
| wr_cmp | output | 1 | Compare field of the written word (always 0) |

## Verification
The assertions assume the detector answer is a pure function of the code, the side and the unit. They also assume that, for a fixed unit and side, the answer changes once as the code rises: 0 below a threshold and 1 at or above it. The bench's detector model follows that rule, with a threshold for each unit and side. The model also gives the inverted answer until det_code has been stable for SETTLE-1 observed cycles, so sampling too early corrupts the results. Thresholds are picked so that searches end both by a normal flip and at each limit. start is driven only between clock edges, and only one spurious start is sent during a run.

// File: rtl/dcc_cal_pkg.sv
package dcc_cal_pkg;

    // Default geometry of the calibration chain
    localparam int DCC_CODE_W_DEF  = 7;
    localparam int DCC_UNITS_DEF   = 10;
    localparam int DCC_SETTLE_DEF  = 128;

    // Sequencer phases
    typedef enum logic [2:0] {
        T_IDLE    = 3'd0,
        T_DLL_OFF = 3'd1,
        T_A_GO    = 3'd2,
        T_A_WAIT  = 3'd3,
        T_B_GO    = 3'd4,
        T_B_WAIT  = 3'd5,
        T_DLL_ON  = 3'd6
    } top_state_t;

    // Single-side search phases
    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_FIRST = 2'd1,
        SR_STEP  = 2'd2
    } srch_state_t;

endpackage

// File: rtl/dcc_settle_timer.sv
module dcc_settle_timer #(
    parameter int SETTLE = 128,
    localparam int CNT_W = (SETTLE > 2) ? $clog2(SETTLE) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic expired
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SETTLE - 1);

    logic [CNT_W-1:0] cnt;
    logic             running;

    assign expired = running && (cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (restart) begin
            cnt     <= '0;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == LAST_CNT) begin
                running <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dcc_side_search.sv
module dcc_side_search
    import dcc_cal_pkg::*;
#(
    parameter int CODE_W = 7,
    parameter int SETTLE = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CODE_W-1:0] seed,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] code,
    output logic              fin,
    output logic              ok
);
    localparam logic [CODE_W-1:0] TOP = '1;

    srch_state_t st;
    logic up;
    logic expired;
    logic load, step, finish, pass;
    logic first_up, first_lim, step_lim, dir_now;

    dcc_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (load | step),
        .expired (expired)
    );

    assign first_up  = !cmp_in;
    assign first_lim = first_up ? (code == TOP) : (code == '0);
    assign step_lim  = up ? (code == TOP) : (code == '0);
    assign dir_now   = (st == SR_FIRST) ? first_up : up;

    always_comb begin
        load   = (st == SR_IDLE) && go;
        step   = 1'b0;
        finish = 1'b0;
        pass   = 1'b0;
        case (st)
            SR_FIRST: if (expired) begin
                if (first_lim) finish = 1'b1;
                else           step   = 1'b1;
            end
            SR_STEP: if (expired) begin
                if (step_lim) begin
                    finish = 1'b1;
                end else if (cmp_in == up) begin
                    finish = 1'b1;
                    pass   = 1'b1;
                end else begin
                    step = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SR_IDLE;
            code <= '0;
            up   <= 1'b0;
            fin  <= 1'b0;
            ok   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                code <= seed;
                st   <= SR_FIRST;
            end
            if ((st == SR_FIRST) && expired) begin
                up <= first_up;
            end
            if (step) begin
                code <= dir_now ? code + 1'b1 : code - 1'b1;
                st   <= SR_STEP;
            end
            if (finish) begin
                fin <= 1'b1;
                ok  <= pass;
                st  <= SR_IDLE;
            end
        end
    end
endmodule

// File: rtl/dcc_side_merge.sv
module dcc_side_merge #(
    parameter int CODE_W = 7
) (
    input  logic              a_ok,
    input  logic [CODE_W-1:0] a_code,
    input  logic              b_ok,
    input  logic [CODE_W-1:0] b_code,
    output logic              m_ok,
    output logic [CODE_W-1:0] m_code
);
    logic [CODE_W:0] sum;

    assign sum  = {1'b0, a_code} + {1'b0, b_code};
    assign m_ok = a_ok | b_ok;

    always_comb begin
        if (a_ok && b_ok) m_code = sum[CODE_W:1];
        else if (a_ok)    m_code = a_code;
        else              m_code = b_code;
    end
endmodule

// File: rtl/dcc_cal_seq.sv
module dcc_cal_seq
    import dcc_cal_pkg::*;
#(
    parameter int CODE_W    = DCC_CODE_W_DEF,
    parameter int NUM_UNITS = DCC_UNITS_DEF,
    parameter int SETTLE    = DCC_SETTLE_DEF,
    localparam int IDX_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [IDX_W-1:0]  fail_unit,
    output logic [IDX_W-1:0]  unit_addr,
    output logic [CODE_W-1:0] det_code,
    output logic              det_corr_en,
    output logic              det_side_a,
    input  logic              det_compare,
    output logic              dll_wr,
    output logic              dll_update_en,
    output logic              dll_good,
    output logic              wr_en,
    output logic [CODE_W-1:0] wr_code,
    output logic              wr_cmp
);
    localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [IDX_W-1:0]  LAST = IDX_W'(NUM_UNITS - 1);

    top_state_t        st;
    logic [IDX_W-1:0]  unit;
    logic [CODE_W-1:0] seed, a_code, b_seed, srch_seed, srch_code, m_code;
    logic              a_ok, srch_go, srch_fin, srch_ok, m_ok;

    assign b_seed    = (a_code == '0) ? '0 : a_code - 1'b1;
    assign srch_go   = (st == T_A_GO) || (st == T_B_GO);
    assign srch_seed = (st == T_B_GO) ? b_seed : seed;

    dcc_side_search #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_search (
        .clk    (clk),
        .rst    (rst),
        .go     (srch_go),
        .seed   (srch_seed),
        .cmp_in (det_compare),
        .code   (srch_code),
        .fin    (srch_fin),
        .ok     (srch_ok)
    );

    dcc_side_merge #(.CODE_W(CODE_W)) u_merge (
        .a_ok   (a_ok),
        .a_code (a_code),
        .b_ok   (srch_ok),
        .b_code (srch_code),
        .m_ok   (m_ok),
        .m_code (m_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            unit      <= '0;
            seed      <= MID;
            a_ok      <= 1'b0;
            a_code    <= '0;
            fail      <= 1'b0;
            fail_unit <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                T_IDLE: if (start) begin
                    st        <= T_DLL_OFF;
                    unit      <= '0;
                    seed      <= MID;
                    fail      <= 1'b0;
                    fail_unit <= '0;
                end
                T_DLL_OFF: begin
                    if (unit == LAST) begin
                        unit <= '0;
                        st   <= T_A_GO;
                    end else begin
                        unit <= unit + 1'b1;
                    end
                end
                T_A_GO: st <= T_A_WAIT;
                T_A_WAIT: if (srch_fin) begin
                    a_ok   <= srch_ok;
                    a_code <= srch_code;
                    st     <= T_B_GO;
                end
                T_B_GO: st <= T_B_WAIT;
                T_B_WAIT: if (srch_fin) begin
                    if (m_ok) begin
                        seed <= m_code;
                        if (unit == LAST) begin
                            unit <= '0;
                            st   <= T_DLL_ON;
                        end else begin
                            unit <= unit + 1'b1;
                            st   <= T_A_GO;
                        end
                    end else begin
                        fail      <= 1'b1;
                        fail_unit <= unit;
                        st        <= T_IDLE;
                    end
                end
                T_DLL_ON: begin
                    if (unit == LAST) begin
                        unit <= '0;
                        done <= 1'b1;
                        st   <= T_IDLE;
                    end else begin
                        unit <= unit + 1'b1;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    assign busy          = (st != T_IDLE);
    assign unit_addr     = unit;
    assign det_code      = srch_code;
    assign det_corr_en   = (st == T_A_WAIT) || (st == T_B_WAIT);
    assign det_side_a    = (st == T_A_GO) || (st == T_A_WAIT);
    assign dll_wr        = (st == T_DLL_OFF) || (st == T_DLL_ON);
    assign dll_update_en = (st == T_DLL_ON);
    assign dll_good      = 1'b0;
    assign wr_en         = (st == T_B_WAIT) && srch_fin && m_ok;
    assign wr_code       = m_code;
    assign wr_cmp        = 1'b0;
endmodule

// File: rtl/dcc_cal_seq_chk.sv
module dcc_cal_seq_chk #(
    parameter int CODE_W = 7,
    parameter int SETTLE = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [CODE_W-1:0] det_code,
    input logic              det_corr_en,
    input logic              det_side_a,
    input logic              wr_en
);
    localparam int HW = $clog2(SETTLE + 1);

    logic [CODE_W-1:0] prev_code;
    logic [HW-1:0]     held;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_code <= '0;
            held      <= '0;
        end else begin
            prev_code <= det_code;
            if (det_code != prev_code)       held <= HW'(1);
            else if (held < HW'(SETTLE))     held <= held + 1'b1;
        end
    end

    // R2: while searching one side, the code only moves by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        (det_corr_en && $past(det_corr_en) && (det_side_a == $past(det_side_a))
         && (det_code != $past(det_code)))
        |-> ((det_code == $past(det_code) + 1'b1) || (det_code == $past(det_code) - 1'b1)));

    // R4: a stepped code was held for the full settle window
    a_r4_settle_hold: assert property (@(posedge clk) disable iff (rst)
        (det_corr_en && $past(det_corr_en) && (det_code != $past(det_code)))
        |-> (held >= HW'(SETTLE)));

    // R7: a unit write closes the search window
    a_r7_wr_ends_search: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !det_corr_en);

    // R9: done is a single-cycle pulse outside a run
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: failure stops the run and is held until a new start
    a_r10_fail_idle: assert property (@(posedge clk) disable iff (rst)
        fail |-> !busy);

    a_r10_fail_hold: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);
endmodule

bind dcc_cal_seq dcc_cal_seq_chk #(.CODE_W(CODE_W), .SETTLE(SETTLE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .det_code    (det_code),
    .det_corr_en (det_corr_en),
    .det_side_a  (det_side_a),
    .wr_en       (wr_en)
);

// File: tb/sim_dcc_cal_seq.sv
module sim_dcc_cal_seq;
    localparam int N      = 10;
    localparam int SETTLE = 128;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       busy, done, fail;
    logic [3:0] fail_unit, unit_addr;
    logic [6:0] det_code, wr_code;
    logic       det_corr_en, det_side_a, det_compare;
    logic       dll_wr, dll_update_en, dll_good, wr_en, wr_cmp;

    always #4 clk = ~clk;

    dcc_cal_seq #(.CODE_W(7), .NUM_UNITS(N), .SETTLE(SETTLE)) u0 (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_unit(fail_unit), .unit_addr(unit_addr),
        .det_code(det_code), .det_corr_en(det_corr_en), .det_side_a(det_side_a),
        .det_compare(det_compare), .dll_wr(dll_wr), .dll_update_en(dll_update_en),
        .dll_good(dll_good), .wr_en(wr_en), .wr_code(wr_code), .wr_cmp(wr_cmp)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Detector model: threshold per unit and side, wrong answer until settled
    int   thA [N];
    int   thB [N];
    int   th_sel;
    int   stab = 0;
    logic [6:0] code_seen = '0;
    logic truth;

    always @(negedge clk) begin
        if (det_code != code_seen) stab = 0;
        else                       stab = stab + 1;
        code_seen = det_code;
    end

    always_comb begin
        th_sel      = det_side_a ? thA[int'(unit_addr)] : thB[int'(unit_addr)];
        truth       = (int'(det_code) >= th_sel);
        det_compare = (stab >= SETTLE - 1) ? truth : !truth;
    end

    // Scoreboard
    typedef struct { int unit; int code; } wr_item_t;
    wr_item_t exp_q[$];
    int off_cnt, on_cnt, done_cnt;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                check(wr_cmp == 1'b0, "R7 write compare field", int'(wr_cmp), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 R7 unexpected write", int'(unit_addr), -1);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(int'(unit_addr) == it.unit, "R7 write unit", int'(unit_addr), it.unit);
                    check(int'(wr_code) == it.code, "R2 R3 R4 R5 R6 unit code", int'(wr_code), it.code);
                end
            end
            if (dll_wr) begin
                check(dll_good == 1'b0, "R8 good flag", int'(dll_good), 0);
                if (!dll_update_en) begin
                    check(int'(unit_addr) == off_cnt, "R8 disable order", int'(unit_addr), off_cnt);
                    off_cnt++;
                end else begin
                    check(int'(unit_addr) == on_cnt, "R8 restore order", int'(unit_addr), on_cnt);
                    on_cnt++;
                end
            end
            if (done) begin
                done_cnt++;
                check(!busy, "R9 done while idle", int'(busy), 0);
            end
        end
    end

    function automatic void ref_side(input int seed, input int th, output bit ok, output int code);
        if (seed >= th) begin
            if (th <= 1) begin ok = 1'b0; code = 0;      end
            else         begin ok = 1'b1; code = th - 1; end
        end else begin
            if (th >= 127) begin ok = 1'b0; code = 127; end
            else           begin ok = 1'b1; code = th;  end
        end
    endfunction

    task automatic run_case(input string name, input bit poke);
        int  seed, exp_fail_unit, bseed, ac, bc, mc, k;
        bit  ao, bo, exp_fail;
        seed = 64;
        exp_fail = 1'b0;
        exp_fail_unit = 0;
        for (int u = 0; u < N; u++) begin
            wr_item_t it;
            ref_side(seed, thA[u], ao, ac);
            bseed = (ac == 0) ? 0 : ac - 1;
            ref_side(bseed, thB[u], bo, bc);
            if (!ao && !bo) begin
                exp_fail = 1'b1;
                exp_fail_unit = u;
                break;
            end
            mc = (ao && bo) ? (ac + bc) / 2 : (ao ? ac : bc);
            it.unit = u;
            it.code = mc;
            exp_q.push_back(it);
            seed = mc;
        end
        off_cnt = 0; on_cnt = 0; done_cnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, {name, " R2 run begins"}, int'(busy), 1);
        k = 0;
        while (busy) begin
            k++;
            start = poke && (k == 2000);
            @(negedge clk);
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, {name, " R7 R10 all writes seen"}, exp_q.size(), 0);
        check(int'(fail) == int'(exp_fail), {name, " R10 fail flag"}, int'(fail), int'(exp_fail));
        if (exp_fail)
            check(int'(fail_unit) == exp_fail_unit, {name, " R10 fail unit"}, int'(fail_unit), exp_fail_unit);
        check(done_cnt == (exp_fail ? 0 : 1), {name, " R9 done count"}, done_cnt, exp_fail ? 0 : 1);
        check(off_cnt == N, {name, " R8 R11 disable strobes"}, off_cnt, N);
        check(on_cnt == (exp_fail ? 0 : N), {name, " R8 R10 restore strobes"}, on_cnt, exp_fail ? 0 : N);
        exp_q.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int u = 0; u < N; u++) begin thA[u] = 66; thB[u] = 67; end
        repeat (4) @(negedge clk);
        check(!busy && !done && !fail && !wr_en && !dll_wr, "R1 reset controls", int'(busy), 0);
        check(det_code == 7'd0 && !det_corr_en && !det_side_a, "R1 reset detector drive", int'(det_code), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !fail && unit_addr == 4'd0, "R1 after release", int'(busy), 0);

        // Rising searches, both sides pass
        for (int u = 0; u < N; u++) begin thA[u] = 66 + (u % 3); thB[u] = 67 + (u % 2); end
        run_case("rising", 1'b0);

        // Falling side A, rising side B, seeds landing on transitions
        for (int u = 0; u < N; u++) begin thA[u] = 60 - u; thB[u] = 61 - u; end
        run_case("falling", 1'b0);

        // One side fails: B hits the top (R3), A hits zero and B seeds at 0 (R5)
        for (int u = 0; u < N; u++) begin
            thA[u] = (u < 4) ? 66 + (u % 3) : 5;
            thB[u] = (u < 4) ? 67 + (u % 2) : 6;
        end
        thB[2] = 128;
        thA[4] = 1;
        thB[4] = 3;
        run_case("one-side R3 R5 R6", 1'b0);

        // Both fail at unit 1: A falls to 0, B seeded at 0 fails at once (R3)
        for (int u = 0; u < N; u++) begin thA[u] = 66; thB[u] = 67; end
        thA[1] = 0;
        thB[1] = 0;
        run_case("both-fail R3 R10", 1'b0);

        // Fail cleared by a new start; spurious start mid-run ignored (R11)
        for (int u = 0; u < N; u++) begin thA[u] = 66 + (u % 3); thB[u] = 67 + (u % 2); end
        run_case("restart R10 R11", 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule